// File: doc/BRIEF.md
# Masked Per-Lane Edge Detector Bank

The block watches a wide bundle of trace input lanes and reports, for every lane separately, when that lane has changed in the way software asked for. Each lane carries a 2-bit mode code that selects rising-edge, falling-edge or both-edge (toggle) detection. A fourth code is reserved and never reports anything. Each lane also has an enable bit in a mask bank, and a lane whose bit is clear never reports an event.

Both configuration banks sit behind one word-addressed register port with a write strobe and a read strobe. The control bank has at most 16 slots of 32 bits, each slot packing 16 lanes at 2 bits per lane. The mask bank has at most 8 slots of 32 bits, one bit per lane. Parameters choose how many slots of each bank actually exist. The full address range of both banks is always safe to access: writes to slots that do not exist change nothing, and reads from them return zero.

Events come out as a per-lane vector and a single "any lane fired" flag. Both are registered in the same clock edge, one cycle after the input change is sampled.

Top module: `edge_lane_bank`

## Requirements
- R1: A lane with mode code 2'b00 whose enable bit is set raises its event bit when it goes from 0 to 1, and not otherwise.
- R2: A lane with mode code 2'b01 whose enable bit is set raises its event bit when it goes from 1 to 0, and not otherwise.
- R3: A lane with mode code 2'b10 whose enable bit is set raises its event bit on any change of its level.
- R4: A lane with mode code 2'b11 never raises its event bit.
- R5: A lane whose enable bit is 1 may report events. A lane whose enable bit is 0 holds its event bit low whatever its mode and input do.
- R6: The input is registered once to form the previous sample. An event bit is high for exactly one cycle, in the cycle after the clock edge that first samples the changed level, and is low again if the level then holds.
- R7: `edge_any` equals the OR of all event bits, in the same cycle.
- R8: Word address s (0..15) is control slot s. Lane l takes its mode from control slot l/16, bits [2*(l%16)+1 : 2*(l%16)]. Word address 16+m (m = 0..7) is mask slot m, and lane l takes its enable bit from mask slot l/32, bit l%32. A read returns the addressed implemented slot's value on `reg_rdata` after the clock edge that samples `reg_rd`, and `reg_rdata` holds that value until the next read.
- R9: A write to a control slot at or above CTRL_REGS, to a mask slot at or above MASK_REGS, or to a word address of 24 or above changes no stored value and no lane's behaviour.
- R10: A read of a non-existent slot or of a word address of 24 or above returns zero.
- R11: Reset clears every control and mask slot, so every lane is disabled, and drives all event outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_in | input | LANES | Trace input lanes |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address of the register slot |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| edge_evt | output | LANES | Per-lane event vector, registered |
| edge_any | output | 1 | OR of all event bits, registered |

## Verification
The bench builds the block with LANES=32, CTRL_REGS=2 and MASK_REGS=1. With these values most of the address space maps to slots that do not exist, in both banks, so ignored writes and zero reads can be tried at the bottom, middle and top of each bank and above the last one. Two control slots bring the field boundary between slot 0 and slot 1 into reach, where lanes 16 and 17 take their modes from the second slot. With one mask word every lane's enable bit can be observed through a single readback.

// File: rtl/edge_bank_pkg.sv
`timescale 1ns/1ps
package edge_bank_pkg;

  localparam int REG_W          = 32;
  localparam int MAX_CTRL_SLOTS = 16;
  localparam int MAX_MASK_SLOTS = 8;
  localparam int LANES_PER_CTRL = 16;
  localparam int LANES_PER_MASK = 32;
  localparam int MASK_BASE      = MAX_CTRL_SLOTS;
  localparam int SPACE_END      = MASK_BASE + MAX_MASK_SLOTS;
  localparam int MAX_LANES      = MAX_CTRL_SLOTS * LANES_PER_CTRL;

  typedef enum logic [1:0] {
    MODE_RISE = 2'b00,
    MODE_FALL = 2'b01,
    MODE_BOTH = 2'b10,
    MODE_RSVD = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       is_ctrl;
    logic       is_mask;
    logic [3:0] slot;
  } slot_sel_t;

  // Edge decision for one lane from its previous and present sample.
  function automatic logic edge_hit(input logic [1:0] mode,
                                    input logic prev_s,
                                    input logic cur_s);
    logic hit;
    case (mode)
      MODE_RISE: hit = !prev_s &&  cur_s;
      MODE_FALL: hit =  prev_s && !cur_s;
      MODE_BOTH: hit =  prev_s !=  cur_s;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Splits a word address into bank and slot.
  function automatic slot_sel_t decode_slot(input int unsigned word);
    slot_sel_t s;
    s = '0;
    if (word < MASK_BASE) begin
      s.is_ctrl = 1'b1;
      s.slot    = 4'(word);
    end else if (word < SPACE_END) begin
      s.is_mask = 1'b1;
      s.slot    = 4'(word - MASK_BASE);
    end
    return s;
  endfunction

  function automatic int ctrl_slot_of(input int lane);
    return lane / LANES_PER_CTRL;
  endfunction

  function automatic int ctrl_lsb_of(input int lane);
    return 2 * (lane % LANES_PER_CTRL);
  endfunction

  function automatic int mask_slot_of(input int lane);
    return lane / LANES_PER_MASK;
  endfunction

  function automatic int mask_bit_of(input int lane);
    return lane % LANES_PER_MASK;
  endfunction

endpackage

// File: rtl/edge_cfg_regs.sv
`timescale 1ns/1ps
module edge_cfg_regs
  import edge_bank_pkg::*;
#(
  parameter int LANES     = 256,
  parameter int CTRL_REGS = 16,
  parameter int MASK_REGS = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [2*LANES-1:0]  lane_mode,
  output logic [LANES-1:0]    lane_mask,
  output logic                wr_ignored,
  output logic                rd_unimpl
);

  logic [REG_W-1:0] ctrl_q [CTRL_REGS];
  logic [REG_W-1:0] mask_q [MASK_REGS];
  slot_sel_t        sel;
  logic             ctrl_hit;
  logic             mask_hit;
  logic [REG_W-1:0] rd_word;

  always_comb begin
    sel      = decode_slot(32'(reg_addr));
    ctrl_hit = sel.is_ctrl && (int'(sel.slot) < CTRL_REGS);
    mask_hit = sel.is_mask && (int'(sel.slot) < MASK_REGS);
  end

  assign wr_ignored = reg_wr && !ctrl_hit && !mask_hit;
  assign rd_unimpl  = reg_rd && !ctrl_hit && !mask_hit;

  // Control slot storage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < CTRL_REGS; s++) ctrl_q[s] <= '0;
    end else if (reg_wr && ctrl_hit) begin
      for (int s = 0; s < CTRL_REGS; s++)
        if (sel.slot == 4'(s)) ctrl_q[s] <= reg_wdata;
    end
  end

  // Mask slot storage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < MASK_REGS; s++) mask_q[s] <= '0;
    end else if (reg_wr && mask_hit) begin
      for (int s = 0; s < MASK_REGS; s++)
        if (sel.slot == 4'(s)) mask_q[s] <= reg_wdata;
    end
  end

  // Readback select; non-existent slots yield zero.
  always_comb begin
    rd_word = '0;
    if (ctrl_hit) begin
      for (int s = 0; s < CTRL_REGS; s++)
        if (sel.slot == 4'(s)) rd_word = ctrl_q[s];
    end else if (mask_hit) begin
      for (int s = 0; s < MASK_REGS; s++)
        if (sel.slot == 4'(s)) rd_word = mask_q[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

  // Fan the slots out to per-lane mode and enable.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int CS = ctrl_slot_of(l);
    localparam int CB = ctrl_lsb_of(l);
    localparam int MS = mask_slot_of(l);
    localparam int MB = mask_bit_of(l);
    if (CS < CTRL_REGS) begin : g_mode
      assign lane_mode[2*l +: 2] = ctrl_q[CS][CB +: 2];
    end else begin : g_mode_none
      assign lane_mode[2*l +: 2] = MODE_RISE;
    end
    if (MS < MASK_REGS) begin : g_en
      assign lane_mask[l] = mask_q[MS][MB];
    end else begin : g_en_none
      assign lane_mask[l] = 1'b0;
    end
  end

endmodule

// File: rtl/edge_lane_unit.sv
`timescale 1ns/1ps
module edge_lane_unit
  import edge_bank_pkg::*;
(
  input  logic       prev_s,
  input  logic       cur_s,
  input  logic [1:0] mode,
  input  logic       enable,
  output logic       hit
);

  assign hit = enable && edge_hit(mode, prev_s, cur_s);

endmodule

// File: rtl/edge_detect_array.sv
`timescale 1ns/1ps
module edge_detect_array #(
  parameter int LANES = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   lane_in,
  input  logic [2*LANES-1:0] lane_mode,
  input  logic [LANES-1:0]   lane_mask,
  output logic [LANES-1:0]   edge_evt,
  output logic               edge_any
);

  logic [LANES-1:0] prev_q;
  logic [LANES-1:0] hit_now;

  for (genvar l = 0; l < LANES; l++) begin : g_unit
    edge_lane_unit u_unit (
      .prev_s (prev_q[l]),
      .cur_s  (lane_in[l]),
      .mode   (lane_mode[2*l +: 2]),
      .enable (lane_mask[l]),
      .hit    (hit_now[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      edge_evt <= '0;
      edge_any <= 1'b0;
    end else begin
      prev_q   <= lane_in;
      edge_evt <= hit_now;
      edge_any <= |hit_now;
    end
  end

endmodule

// File: rtl/edge_lane_bank.sv
`timescale 1ns/1ps
module edge_lane_bank
  import edge_bank_pkg::*;
#(
  parameter int LANES     = 256,
  parameter int CTRL_REGS = 16,
  parameter int MASK_REGS = 8,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [LANES-1:0]  edge_evt,
  output logic              edge_any
);

  logic [2*LANES-1:0] lane_mode;
  logic [LANES-1:0]   lane_mask;
  logic               wr_ignored;
  logic               rd_unimpl;

  edge_cfg_regs #(
    .LANES     (LANES),
    .CTRL_REGS (CTRL_REGS),
    .MASK_REGS (MASK_REGS),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .lane_mode  (lane_mode),
    .lane_mask  (lane_mask),
    .wr_ignored (wr_ignored),
    .rd_unimpl  (rd_unimpl)
  );

  edge_detect_array #(
    .LANES (LANES)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_in   (lane_in),
    .lane_mode (lane_mode),
    .lane_mask (lane_mask),
    .edge_evt  (edge_evt),
    .edge_any  (edge_any)
  );

endmodule

// File: rtl/edge_lane_bank_chk.sv
`timescale 1ns/1ps
module edge_lane_bank_chk #(
  parameter int LANES = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LANES-1:0]   lane_in,
  input logic [2*LANES-1:0] lane_mode,
  input logic [LANES-1:0]   lane_mask,
  input logic [LANES-1:0]   edge_evt,
  input logic               edge_any,
  input logic               wr_ignored,
  input logic               rd_unimpl,
  input logic [31:0]        reg_rdata
);

  // Two edges after reset the previous-sample register holds live data.
  logic [1:0] age;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= 2'd0;
    else if (age != 2'd2)  age <= age + 2'd1;
  end
  assign armed = (age == 2'd2);

  for (genvar l = 0; l < LANES; l++) begin : g_prop
    AST_RISE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(lane_mode[2*l +: 2]) == 2'b00 && $past(lane_mask[l])) |->
        (edge_evt[l] == ($past(lane_in[l]) && !$past(lane_in[l], 2)))); // R1
    AST_FALL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(lane_mode[2*l +: 2]) == 2'b01 && $past(lane_mask[l])) |->
        (edge_evt[l] == (!$past(lane_in[l]) && $past(lane_in[l], 2)))); // R2
    AST_BOTH_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(lane_mode[2*l +: 2]) == 2'b10 && $past(lane_mask[l])) |->
        (edge_evt[l] == ($past(lane_in[l]) != $past(lane_in[l], 2)))); // R3
    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(lane_mode[2*l +: 2]) == 2'b11) |-> !edge_evt[l]); // R4
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && edge_evt[l]) |-> $past(lane_mask[l])); // R5
  end

  AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    edge_any == (edge_evt != '0)); // R7

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> ($stable(lane_mode) && $stable(lane_mask))); // R9

  AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unimpl |=> (reg_rdata == 32'd0)); // R10

endmodule

bind edge_lane_bank edge_lane_bank_chk #(
  .LANES (LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lane_in    (lane_in),
  .lane_mode  (lane_mode),
  .lane_mask  (lane_mask),
  .edge_evt   (edge_evt),
  .edge_any   (edge_any),
  .wr_ignored (wr_ignored),
  .rd_unimpl  (rd_unimpl),
  .reg_rdata  (reg_rdata)
);

// File: tb/edge_lane_bank_tb.sv
`timescale 1ns/1ps
module edge_lane_bank_tb;

  localparam int LANES     = 32;
  localparam int CTRL_REGS = 2;
  localparam int MASK_REGS = 1;
  localparam int ADDR_W    = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LANES-1:0]  lane_in = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [LANES-1:0]  edge_evt;
  logic              edge_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench view of the register contents, kept by its own address rules.
  logic [31:0] bm_ctrl [16];
  logic [31:0] bm_mask [8];
  logic [LANES-1:0] drv = '0;

  always #2.5 clk = ~clk;

  edge_lane_bank #(
    .LANES (LANES), .CTRL_REGS (CTRL_REGS), .MASK_REGS (MASK_REGS), .ADDR_W (ADDR_W)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .lane_in (lane_in),
    .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .edge_evt (edge_evt), .edge_any (edge_any)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a < 16 && a < CTRL_REGS) bm_ctrl[a] = d;
    else if (a >= 16 && a < 16 + MASK_REGS) bm_mask[a-16] = d;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_read(input int a);
    if (a < 16 && a < CTRL_REGS) return bm_ctrl[a];
    if (a >= 16 && a < 16 + MASK_REGS) return bm_mask[a-16];
    return 32'd0;
  endfunction

  function automatic logic [LANES-1:0] exp_events(input logic [LANES-1:0] p,
                                                  input logic [LANES-1:0] c);
    logic [LANES-1:0] e;
    e = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [1:0] m;
      logic       en;
      m  = (l / 16 < CTRL_REGS) ? bm_ctrl[l/16][2*(l%16) +: 2] : 2'b00;
      en = (l / 32 < MASK_REGS) ? bm_mask[l/32][l%32] : 1'b0;
      if (en) begin
        if (m == 2'b00) e[l] = !p[l] && c[l];
        if (m == 2'b01) e[l] = p[l] && !c[l];
        if (m == 2'b10) e[l] = p[l] ^ c[l];
      end
    end
    return e;
  endfunction

  // Drive a new level at a falling edge; one rising edge later the event is registered.
  task automatic step(input logic [LANES-1:0] v, input string req,
                      output logic [LANES-1:0] exp);
    logic [LANES-1:0] p;
    @(negedge clk);
    p = drv; drv = v; lane_in = v;
    exp = exp_events(p, v);
    @(negedge clk);
    check(req, "event vector", 64'(edge_evt), 64'(exp));
    check("R7", "any flag", 64'(edge_any), 64'(exp != '0));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R11", "events after reset", 64'(edge_evt), 64'd0);
    check("R11", "any after reset", 64'(edge_any), 64'd0);
    reg_read(0, d);  check("R11", "ctrl0 reset", 64'(d), 64'd0);
    reg_read(1, d);  check("R11", "ctrl1 reset", 64'(d), 64'd0);
    reg_read(16, d); check("R11", "mask0 reset", 64'(d), 64'd0);
  endtask

  task automatic t_masked_default();
    logic [LANES-1:0] e;
    step('1, "R5", e);
    check("R5", "all lanes disabled rise", 64'(edge_evt), 64'd0);
    step('0, "R5", e);
    check("R5", "all lanes disabled fall", 64'(edge_evt), 64'd0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    // lane0 00, lane1 01, lane2 10, lane3 11, lane4 10; lane16 10
    reg_write(0, 32'h0000_02E4);
    reg_write(1, 32'h0000_0002);
    reg_write(16, 32'h0001_000F);
    reg_read(0, d);  check("R8", "ctrl0 readback", 64'(d), 64'h2E4);
    reg_read(1, d);  check("R8", "ctrl1 readback", 64'(d), 64'h2);
    reg_read(16, d); check("R8", "mask0 readback", 64'(d), 64'h0001_000F);
    @(negedge clk); @(negedge clk);
    check("R8", "rdata held", 64'(reg_rdata), 64'h0001_000F);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    int addrs [5] = '{2, 15, 17, 23, 31};
    foreach (addrs[i]) reg_write(addrs[i], 32'hFFFF_FFFF);
    foreach (addrs[i]) begin
      reg_read(addrs[i], d);
      check("R10", $sformatf("read addr %0d", addrs[i]), 64'(d), 64'(exp_read(addrs[i])));
    end
    reg_read(0, d);  check("R9", "ctrl0 untouched", 64'(d), 64'h2E4);
    reg_read(1, d);  check("R9", "ctrl1 untouched", 64'(d), 64'h2);
    reg_read(16, d); check("R9", "mask0 untouched", 64'(d), 64'h0001_000F);
  endtask

  task automatic t_modes();
    logic [LANES-1:0] e;
    step(32'hFFFF_FFFF, "R1", e);
    check("R1", "lane0 rising fires", 64'(edge_evt[0]), 64'd1);
    check("R2", "lane1 falling quiet on rise", 64'(edge_evt[1]), 64'd0);
    check("R3", "lane2 toggle on rise", 64'(edge_evt[2]), 64'd1);
    check("R4", "lane3 reserved quiet", 64'(edge_evt[3]), 64'd0);
    check("R5", "lane4 masked", 64'(edge_evt[4]), 64'd0);
    check("R9", "vector after ignored writes", 64'(edge_evt), 64'h0001_0005);
    step(32'hFFFF_FFFF, "R6", e);
    check("R6", "held level gives no event", 64'(edge_evt), 64'd0);
    step(32'h0000_0000, "R2", e);
    check("R2", "lane1 falling fires", 64'(edge_evt[1]), 64'd1);
    check("R1", "lane0 rising quiet on fall", 64'(edge_evt[0]), 64'd0);
    check("R3", "toggle on fall", 64'(edge_evt), 64'h0001_0006);
    step(32'h0000_0008, "R4", e);
    check("R4", "reserved rise silent", 64'(edge_evt), 64'd0);
    check("R7", "any low when none", 64'(edge_any), 64'd0);
    step(32'h0001_0003, "R1", e);
    check("R1", "mixed pattern", 64'(edge_evt), 64'h0001_0001);
    step(32'h5555_5555, "R3", e);
    step(32'hAAAA_AAAA, "R3", e);
  endtask

  task automatic t_second_slot();
    logic [LANES-1:0] e;
    // lane16 rising (00), lane17 falling (01) in ctrl slot 1; enable lanes 16,17 only
    reg_write(1, 32'h0000_0004);
    reg_write(16, 32'h0003_0000);
    step(32'h0003_0000, "R8", e);
    check("R8", "lane17 falling quiet on rise", 64'(edge_evt), 64'h0001_0000);
    step(32'h0000_0000, "R8", e);
    check("R8", "lane17 falling from slot1 bits 3:2", 64'(edge_evt), 64'h0002_0000);
    step(32'h0000_FFFF, "R5", e);
    check("R5", "lanes 0..15 now disabled", 64'(edge_evt), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) bm_ctrl[i] = '0;
    for (int i = 0; i < 8; i++)  bm_mask[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_default();
    t_readback();
    t_unimpl();
    t_modes();
    t_second_slot();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule